// File: doc/BRIEF.md
# Address-Triggered Shift/Load Write Latch

This block is the data latch of a floppy-style write path that hangs on a CPU bus. It has no read/write input. Its operating mode is set only by the low address lines of a selected bus access. In shift mode it sends the byte it holds toward the write head one bit at a time, most significant bit first, advancing on each shift-clock enable. A selected access to the load address arms load mode. The latch then takes whatever byte is on the data bus in the next bus cycle and returns to shift mode.

Software therefore writes a byte with two accesses to the load address. The first is a dummy read that arms load mode. The second is the real write, whose data lands on the bus in the cycle the latch captures. If the write comes without the arming access, its data has left the bus before load mode begins. The latch then captures whatever the following cycle carries, and the written byte is lost.

Top module: `shift_load_latch`

## Requirements
- R1: After reset the held byte is zero, `mode_load` is 0 (shift mode) and `wr_bit` is 0.
- R2: A cycle with `sel` high and `addr` equal to LOAD_ADDR (default 4'hD), outside a capture cycle, sets `mode_load` to 1 from the next clock edge. No read/write qualifier exists.
- R3: A selected access to SHIFT_ADDR (default 4'hC) leaves `mode_load` at 0. With `shift_en` low the held byte is unchanged.
- R4: Cycles with `sel` low, and selected accesses to any address other than LOAD_ADDR and SHIFT_ADDR, do not change the mode.
- R5: In a cycle where `mode_load` is 1, the clock edge ending it copies `bus_data` into the held byte. It does so whatever the address or `sel`, and `shift_en` has no effect in that cycle.
- R6: The edge that captures the byte returns `mode_load` to 0, and the address of the capture cycle does not re-arm load mode.
- R7: In shift mode each cycle with `shift_en` high shifts the held byte left by one with a zero fill. `wr_bit` always shows the held byte's bit 7 (MSB), so the byte leaves MSB first.
- R8: In shift mode with `shift_en` low the held byte does not change.
- R9: A lone load-address access that carries the data sets the mode only. The byte captured is the one on the bus in the following cycle, so the data of the lone access is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Device select for the current bus cycle |
| addr | input | ADDR_W (4) | Low address lines that choose the mode |
| bus_data | input | DATA_W (8) | CPU data bus |
| shift_en | input | 1 | Shift-clock enable, one bit per high cycle |
| wr_bit | output | 1 | Serial bit toward the write head (held byte MSB) |
| mode_load | output | 1 | 1 when load mode is armed for the next capture |

## Verification
A mode change is due one edge after the selecting cycle. A capture is due one edge after a cycle in which `mode_load` reads 1. `wr_bit` shows each new bit one edge after the `shift_en` cycle. The bench drives inputs just after a rising edge, so they are stable for one full cycle. It reads the outputs one nanosecond after the next rising edge, when every result caused by the previous cycle has settled. It sweeps all 256 byte values through the arm, write and shift-out sequence and all 16 addresses with `sel` high and low. The expected bits are computed from the byte value.

// File: rtl/slatch_pkg.sv
package slatch_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_LOAD  = 1'b1
  } latch_mode_e;
endpackage

// File: rtl/slatch_mode_ctl.sv
module slatch_mode_ctl
  import slatch_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int LOAD_ADDR  = 13,
  parameter int SHIFT_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              load_hit,
  output logic              shift_hit,
  output logic              capture,
  output latch_mode_e       mode_q
);
  localparam logic [ADDR_W-1:0] LoadA  = ADDR_W'(LOAD_ADDR);
  localparam logic [ADDR_W-1:0] ShiftA = ADDR_W'(SHIFT_ADDR);

  function automatic logic decode_hit(input logic s, input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] target);
    return s && (a == target);
  endfunction

  latch_mode_e mode_d;

  assign load_hit  = decode_hit(sel, addr, LoadA);
  assign shift_hit = decode_hit(sel, addr, ShiftA);
  assign capture   = (mode_q == MODE_LOAD);

  always_comb begin
    mode_d = mode_q;
    if (capture)        mode_d = MODE_SHIFT;
    else if (load_hit)  mode_d = MODE_LOAD;
    else if (shift_hit) mode_d = MODE_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_SHIFT;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/slatch_shreg.sv
module slatch_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] bus_data,
  output logic              shift_step,
  output logic [DATA_W-1:0] held_q,
  output logic              msb
);
  function automatic logic [DATA_W-1:0] shift_left(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], 1'b0};
  endfunction

  assign shift_step = shift_en && !capture;
  assign msb        = held_q[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)          held_q <= '0;
    else if (capture)    held_q <= bus_data;
    else if (shift_step) held_q <= shift_left(held_q);
  end
endmodule

// File: rtl/shift_load_latch.sv
module shift_load_latch
  import slatch_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int LOAD_ADDR  = 13,
  parameter int SHIFT_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              shift_en,
  output logic              wr_bit,
  output logic              mode_load
);
  logic              load_hit;
  logic              shift_hit;
  logic              capture;
  logic              shift_step;
  latch_mode_e       mode_q;
  logic [DATA_W-1:0] held_q;

  slatch_mode_ctl #(
    .ADDR_W(ADDR_W), .LOAD_ADDR(LOAD_ADDR), .SHIFT_ADDR(SHIFT_ADDR)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr),
    .load_hit(load_hit), .shift_hit(shift_hit), .capture(capture), .mode_q(mode_q)
  );

  slatch_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .capture(capture), .shift_en(shift_en),
    .bus_data(bus_data), .shift_step(shift_step), .held_q(held_q), .msb(wr_bit)
  );

  assign mode_load = (mode_q == MODE_LOAD);
endmodule

// File: rtl/shift_load_latch_chk.sv
module shift_load_latch_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              shift_en,
  input logic              mode_load,
  input logic              load_hit,
  input logic              shift_hit,
  input logic [DATA_W-1:0] held_q
);
  a_r2_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hit && !mode_load) |=> mode_load);

  a_r3_shift_addr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_hit && !mode_load) |=> !mode_load);

  a_r4_idle_keeps_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !mode_load) |=> !mode_load);

  a_r5_capture_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (held_q == $past(bus_data)));

  a_r6_capture_returns: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> !mode_load);

  a_r7_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_load && shift_en) |=> (held_q == {$past(held_q[DATA_W-2:0]), 1'b0}));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_load && !shift_en) |=> $stable(held_q));
endmodule

bind shift_load_latch shift_load_latch_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .bus_data(bus_data),
  .shift_en(shift_en), .mode_load(mode_load), .load_hit(load_hit),
  .shift_hit(shift_hit), .held_q(held_q)
);

// File: tb/shift_load_latch_tb.sv
`timescale 1ns/1ps
module shift_load_latch_tb;
  localparam int LOADA  = 13;
  localparam int SHIFTA = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] bus_data = '0;
  logic       shift_en = 1'b0;
  logic       wr_bit;
  logic       mode_load;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  shift_load_latch u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .bus_data(bus_data),
    .shift_en(shift_en), .wr_bit(wr_bit), .mode_load(mode_load)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one bus cycle, then sample 1 ns after the edge that ends it
  task automatic cyc(input logic s, input logic [3:0] a, input logic [7:0] d, input logic se);
    sel = s; addr = a; bus_data = d; shift_en = se;
    @(posedge clk); #1;
    sel = 1'b0; addr = '0; bus_data = '0; shift_en = 1'b0;
  endtask

  // shift the byte out and compare every bit with the expected MSB-first order
  task automatic drain(input logic [7:0] exp, input string req);
    for (int i = 7; i >= 0; i--) begin
      chk(req, {7'd0, wr_bit}, {7'd0, exp[i]});
      cyc(1'b0, 4'd0, 8'd0, 1'b1);
    end
    chk(req, {7'd0, wr_bit}, 8'd0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 mode", {7'd0, mode_load}, 8'd0);
    chk("R1 wr_bit", {7'd0, wr_bit}, 8'd0);
    drain(8'h00, "R1 held zero");

    // R2 R5 R6 R7: arm with a dummy access, write, then shift out; every byte
    for (int b = 0; b < 256; b++) begin
      cyc(1'b1, 4'(LOADA), 8'hFF ^ 8'(b), 1'b0);
      chk("R2 armed", {7'd0, mode_load}, 8'd1);
      cyc(1'b1, 4'(LOADA), 8'(b), 1'b1);     // shift_en ignored while capturing (R5)
      chk("R6 back to shift", {7'd0, mode_load}, 8'd0);
      drain(8'(b), "R5 R7 captured byte MSB first");
    end

    // R9: lone write without arming loses its data
    for (int b = 1; b < 256; b += 17) begin
      cyc(1'b1, 4'(LOADA), 8'(b), 1'b0);
      cyc(1'b0, 4'd0, 8'h00, 1'b0);
      chk("R9 mode after capture", {7'd0, mode_load}, 8'd0);
      drain(8'h00, "R9 lone write lost");
    end

    // R4: all addresses, unselected and selected
    for (int a = 0; a < 16; a++) begin
      cyc(1'b0, 4'(a), 8'hA5, 1'b0);
      chk("R4 unselected", {7'd0, mode_load}, 8'd0);
      cyc(1'b1, 4'(a), 8'h5A, 1'b0);
      chk("R4 selected address", {7'd0, mode_load}, {7'd0, a == LOADA});
      if (a == LOADA) begin
        cyc(1'b0, 4'd0, 8'h3C, 1'b0);
        drain(8'h3C, "R5 capture with sel low");
      end
    end

    // R3 R8: shift address and idle cycles keep the held byte
    cyc(1'b1, 4'(LOADA), 8'h00, 1'b0);
    cyc(1'b1, 4'(LOADA), 8'hB6, 1'b0);
    cyc(1'b1, 4'(SHIFTA), 8'h11, 1'b0);
    chk("R3 shift mode", {7'd0, mode_load}, 8'd0);
    for (int k = 0; k < 5; k++) cyc(1'b0, 4'd0, 8'hFF, 1'b0);
    chk("R8 stable mode", {7'd0, mode_load}, 8'd0);
    drain(8'hB6, "R3 R8 held byte intact");

    // R6: capture cycle addressed to the load address does not re-arm
    cyc(1'b1, 4'(LOADA), 8'h00, 1'b0);
    cyc(1'b1, 4'(LOADA), 8'h81, 1'b0);
    cyc(1'b0, 4'd0, 8'h00, 1'b0);
    chk("R6 no re-arm", {7'd0, mode_load}, 8'd0);
    drain(8'h81, "R6 byte kept");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule